// File: doc/BRIEF.md
# Quadrature NCO Down-Mixer

This block moves a stream of real, signed converter samples to complex baseband. Every accepted sample advances a phase accumulator by a programmable tuning word. The top bits of that phase address a quarter-wave sine table, and quadrant logic expands the table into a full-circle cosine and a negated sine. The block multiplies the sample by each value and rounds the products to the output width. This gives an in-phase output `x·cos(φ)` and a quadrature output `−x·sin(φ)`.

The tuning word equals round(f_target · 2^PHASE_W / f_sample). With the default 32-bit accumulator at 125 MSPS, one step is about 0.029 Hz. A new word reaches the accumulator with the same sample in which it is loaded, so retuning needs no settling time. The table is built at elaboration from integer arithmetic and needs no memory file. Each result carries the phase it was mixed with, aligned to its valid flag.

Top module: `nco_quad_mixer`

## Requirements
- R1: While reset is asserted and after it is released, `mix_valid`, `mix_i`, `mix_q` and `mix_phase` are 0, the tuning word is 0, and the first sample accepted after reset is mixed at phase 0.
- R2: The phase used for the n-th accepted sample (counting from 0) is the sum of the tuning words in force at the n earlier accepted samples, modulo 2^PHASE_W. Cycles with `samp_valid` low leave the phase unchanged.
- R3: When `tune_load` is high, `tune_word` becomes the word in force in that same cycle. An accepted sample in that cycle keeps the old phase, and the step it adds to the accumulator is the new word. A load with no sample changes only the word.
- R4: A sample captured at a rising edge with `samp_valid` high produces `mix_valid` high after the third following rising edge (four register stages). `mix_valid` is otherwise low.
- R5: `mix_phase` shows the full accumulator phase used for the result presented with it.
- R6: The table index k is the top QTR_BITS+2 phase bits, so θ = 2π·k/2^(QTR_BITS+2). With `mix_valid` high, `mix_i` lies within 1 LSB of x·A·cos(θ)/2^(IN_W−1), where A = 2^(LUT_W−1)−1. With the defaults this is x·32767·cos(θ)/8192 with θ = 2π·k/4096.
- R7: Under the same conditions, `mix_q` lies within 1 LSB of −x·A·sin(θ)/2^(IN_W−1).
- R8: At the four axis phases (k a multiple of 2^QTR_BITS, quadrants 0 to 3), cos takes the values +A, 0, −A, 0 and sin takes 0, +A, 0, −A exactly. The products are rounded half up: (p + 2^(S−1)) >> S with S = IN_W+LUT_W−1−OUT_W (13 by default).
- R9: Outputs are clamped to the symmetric range ±(2^(OUT_W−1)−1). A full-scale negative sample (−8192) at phase 0 gives I = −32767, and at phase 2^31 it gives I = +32767.
- R10: A zero sample gives exactly zero on both outputs at any phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| samp_valid | input | 1 | Qualifies `samp_data` |
| samp_data | input | IN_W | Signed two's-complement input sample |
| tune_load | input | 1 | Loads `tune_word` as the tuning word |
| tune_word | input | PHASE_W | Unsigned phase step per sample |
| mix_valid | output | 1 | Qualifies the mixer outputs |
| mix_i | output | OUT_W | Signed in-phase result |
| mix_q | output | OUT_W | Signed quadrature result |
| mix_phase | output | PHASE_W | Phase used for the current result |

## Verification
Every mixed result, with its phase, is due exactly four edges after the edge that captures its sample. The bench drives inputs on falling edges. It files each expected result in an eight-entry ring slot four cycles ahead and compares that slot on the falling edge four cycles later. Gaps in `samp_valid` and loads of the tuning word land in known cycles, so the phase model checks the same-cycle effect of a load on the next sample's phase. Axis phases and zero samples are compared exactly. All other phases are compared to a real-valued cosine and sine model within 1 LSB.

// File: rtl/nco_mix_pkg.sv
package nco_mix_pkg;

   // pi/2 in unsigned Q2.30
   localparam longint HALF_PI_Q30 = 64'sd1686629713;
   localparam int     TAYLOR_TERMS = 7;

   // amplitude-scaled sin(k/depth * pi/2), integer Taylor series in Q30
   function automatic int quarter_sine(input int k, input int depth, input int amp);
      longint ang;
      longint ang_sq;
      longint term;
      longint acc;
      ang    = (longint'(k) * HALF_PI_Q30) / longint'(depth);
      ang_sq = (ang * ang) >>> 30;
      term   = ang;
      acc    = ang;
      for (int n = 1; n <= TAYLOR_TERMS; n++) begin
         term = -((term * ang_sq) >>> 30) / longint'(2 * n * (2 * n + 1));
         acc  = acc + term;
      end
      if (acc < 0) acc = 0;
      return int'((acc * longint'(amp) + (64'sd1 <<< 29)) >>> 30);
   endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
   parameter int PHASE_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               smp_valid,
   input  logic               load,
   input  logic [PHASE_W-1:0] word_new,
   output logic [PHASE_W-1:0] acc_q,
   output logic [PHASE_W-1:0] word_q,
   output logic [PHASE_W-1:0] smp_phase,
   output logic               smp_vld
);

   logic [PHASE_W-1:0] step_eff;

   always_comb begin
      step_eff = load ? word_new : word_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q     <= '0;
         word_q    <= '0;
         smp_phase <= '0;
         smp_vld   <= 1'b0;
      end else begin
         smp_vld <= smp_valid;
         if (load) word_q <= word_new;
         if (smp_valid) begin
            smp_phase <= acc_q;
            acc_q     <= acc_q + step_eff;
         end
      end
   end

endmodule

// File: rtl/nco_quarter_lut.sv
module nco_quarter_lut #(
   parameter int QTR_BITS = 10,
   parameter int LUT_W    = 16,
   parameter int QUAD_OFS = 0,
   parameter bit NEGATE   = 1'b0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      en,
   input  logic [QTR_BITS+1:0]       ph_idx,
   output logic signed [LUT_W-1:0]   val_q
);

   localparam int QDEPTH = 1 << QTR_BITS;
   localparam int AMP    = (1 << (LUT_W - 1)) - 1;

   logic [LUT_W-2:0] rom [QDEPTH+1];

   for (genvar g = 0; g <= QDEPTH; g++) begin : g_rom
      assign rom[g] = (LUT_W-1)'(nco_mix_pkg::quarter_sine(g, QDEPTH, AMP));
   end

   logic [1:0]              quad;
   logic [QTR_BITS-1:0]     idx;
   logic [QTR_BITS:0]       addr;
   logic signed [LUT_W-1:0] mag;
   logic                    neg;
   logic signed [LUT_W-1:0] val_d;

   always_comb begin
      quad = ph_idx[QTR_BITS+1:QTR_BITS] + 2'(QUAD_OFS);
      idx  = ph_idx[QTR_BITS-1:0];
      addr = quad[0] ? ((QTR_BITS+1)'(QDEPTH) - {1'b0, idx}) : {1'b0, idx};
      mag  = $signed({1'b0, rom[addr]});
   end

   if (NEGATE) begin : g_neg
      assign neg = ~quad[1];
   end else begin : g_pos
      assign neg = quad[1];
   end

   always_comb begin
      val_d = neg ? -mag : mag;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_q <= '0;
      else if (en) val_q <= val_d;
   end

endmodule

// File: rtl/nco_mix_round.sv
module nco_mix_round #(
   parameter int IN_W  = 14,
   parameter int LUT_W = 16,
   parameter int OUT_W = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     mul_en,
   input  logic                     out_en,
   input  logic signed [IN_W-1:0]   x,
   input  logic signed [LUT_W-1:0]  coef,
   output logic signed [OUT_W-1:0]  y_q
);

   localparam int     PW   = IN_W + LUT_W;
   localparam int     SH   = IN_W + LUT_W - 1 - OUT_W;
   localparam int     RW   = ((PW > OUT_W) ? PW : OUT_W) + 2;
   localparam longint MAXL = (64'sd1 <<< (OUT_W - 1)) - 1;
   localparam logic signed [RW-1:0] MAXV = RW'(MAXL);
   localparam logic signed [RW-1:0] MINV = -MAXV;

   logic signed [PW-1:0]    prod_q;
   logic signed [RW-1:0]    p_ext;
   logic signed [RW-1:0]    r_full;
   logic signed [OUT_W-1:0] y_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prod_q <= '0;
      else if (mul_en) prod_q <= x * coef;
   end

   assign p_ext = {{(RW-PW){prod_q[PW-1]}}, prod_q};

   if (SH > 0) begin : g_shr
      localparam logic signed [RW-1:0] HALF = RW'(64'sd1 <<< (SH - 1));
      assign r_full = (p_ext + HALF) >>> SH;
   end else begin : g_shl
      assign r_full = p_ext <<< (-SH);
   end

   always_comb begin
      if (r_full > MAXV)      y_d = MAXV[OUT_W-1:0];
      else if (r_full < MINV) y_d = MINV[OUT_W-1:0];
      else                    y_d = r_full[OUT_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) y_q <= '0;
      else if (out_en) y_q <= y_d;
   end

endmodule

// File: rtl/nco_quad_mixer.sv
module nco_quad_mixer #(
   parameter int PHASE_W  = 32,
   parameter int QTR_BITS = 10,
   parameter int LUT_W    = 16,
   parameter int IN_W     = 14,
   parameter int OUT_W    = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      samp_valid,
   input  logic signed [IN_W-1:0]    samp_data,
   input  logic                      tune_load,
   input  logic [PHASE_W-1:0]        tune_word,
   output logic                      mix_valid,
   output logic signed [OUT_W-1:0]   mix_i,
   output logic signed [OUT_W-1:0]   mix_q,
   output logic [PHASE_W-1:0]        mix_phase
);

   localparam int IDX_W = QTR_BITS + 2;
   localparam int NCH   = 2;

   if (QTR_BITS < 2 || QTR_BITS > 14) begin : g_bad_qtr
      $error("nco_quad_mixer: QTR_BITS out of range 2..14");
   end
   if (PHASE_W < IDX_W) begin : g_bad_phase
      $error("nco_quad_mixer: PHASE_W narrower than table index");
   end
   if (LUT_W < 4 || LUT_W > 24) begin : g_bad_lut
      $error("nco_quad_mixer: LUT_W out of range 4..24");
   end
   if (IN_W < 2 || OUT_W < 2 || OUT_W > 30) begin : g_bad_io
      $error("nco_quad_mixer: IN_W or OUT_W out of range");
   end

   logic [PHASE_W-1:0]    acc_now;
   logic [PHASE_W-1:0]    tune_now;
   logic [PHASE_W-1:0]    ph1, ph2, ph3;
   logic                  v1, v2, v3;
   logic signed [IN_W-1:0] x1, x2;

   nco_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_valid (samp_valid),
      .load      (tune_load),
      .word_new  (tune_word),
      .acc_q     (acc_now),
      .word_q    (tune_now),
      .smp_phase (ph1),
      .smp_vld   (v1)
   );

   // stage 1 sample register, stages 2/3 alignment registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         x1        <= '0;
         x2        <= '0;
         ph2       <= '0;
         ph3       <= '0;
         mix_phase <= '0;
         v2        <= 1'b0;
         v3        <= 1'b0;
         mix_valid <= 1'b0;
      end else begin
         v2        <= v1;
         v3        <= v2;
         mix_valid <= v3;
         if (samp_valid) x1 <= samp_data;
         if (v1) begin
            x2  <= x1;
            ph2 <= ph1;
         end
         if (v2) ph3 <= ph2;
         if (v3) mix_phase <= ph3;
      end
   end

   logic signed [LUT_W-1:0] osc [NCH];
   logic signed [OUT_W-1:0] res [NCH];

   // channel 0: cos = sin shifted by one quadrant; channel 1: negated sine
   for (genvar c = 0; c < NCH; c++) begin : g_ch
      nco_quarter_lut #(
         .QTR_BITS (QTR_BITS),
         .LUT_W    (LUT_W),
         .QUAD_OFS ((c == 0) ? 1 : 0),
         .NEGATE   ((c == 0) ? 1'b0 : 1'b1)
      ) u_lut (
         .clk    (clk),
         .rst_n  (rst_n),
         .en     (v1),
         .ph_idx (ph1[PHASE_W-1 -: IDX_W]),
         .val_q  (osc[c])
      );

      nco_mix_round #(
         .IN_W  (IN_W),
         .LUT_W (LUT_W),
         .OUT_W (OUT_W)
      ) u_mix (
         .clk    (clk),
         .rst_n  (rst_n),
         .mul_en (v2),
         .out_en (v3),
         .x      (x2),
         .coef   (osc[c]),
         .y_q    (res[c])
      );
   end

   assign mix_i = res[0];
   assign mix_q = res[1];

endmodule

// File: rtl/nco_quad_mixer_chk.sv
module nco_quad_mixer_chk #(
   parameter int PHASE_W  = 32,
   parameter int QTR_BITS = 10,
   parameter int IN_W     = 14,
   parameter int OUT_W    = 16
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     samp_valid,
   input logic signed [IN_W-1:0]   samp_data,
   input logic                     tune_load,
   input logic [PHASE_W-1:0]       tune_word,
   input logic                     mix_valid,
   input logic signed [OUT_W-1:0]  mix_i,
   input logic signed [OUT_W-1:0]  mix_q,
   input logic [PHASE_W-1:0]       mix_phase,
   input logic [PHASE_W-1:0]       acc_now,
   input logic [PHASE_W-1:0]       tune_now
);

   localparam int MAXO  = (1 << (OUT_W - 1)) - 1;
   localparam int IDX_W = QTR_BITS + 2;

   logic [2:0] since;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) since <= '0;
      else if (since != 3'd7) since <= since + 3'd1;
   end

   // R4: result valid four edges after capture
   p_valid_delay_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (since >= 3'd4) |-> (mix_valid == $past(samp_valid, 4)));

   // R9: outputs stay in the symmetric range
   p_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mix_valid |-> (mix_i >= -MAXO && mix_i <= MAXO && mix_q >= -MAXO && mix_q <= MAXO));

   // R2: the phase holds while no sample is accepted
   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !samp_valid |=> $stable(acc_now));

   // R3: a load makes the word current at once
   p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tune_load |=> (tune_now == $past(tune_word)));

   // R10: zero sample gives zero outputs
   p_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (since >= 3'd4 && mix_valid && $past(samp_data, 4) == '0) |-> (mix_i == '0 && mix_q == '0));

   // R8: at table index zero the sine term vanishes
   p_axis_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mix_valid && mix_phase[PHASE_W-1 -: IDX_W] == '0) |-> (mix_q == '0));

endmodule

bind nco_quad_mixer nco_quad_mixer_chk #(
   .PHASE_W  (PHASE_W),
   .QTR_BITS (QTR_BITS),
   .IN_W     (IN_W),
   .OUT_W    (OUT_W)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .samp_valid (samp_valid),
   .samp_data  (samp_data),
   .tune_load  (tune_load),
   .tune_word  (tune_word),
   .mix_valid  (mix_valid),
   .mix_i      (mix_i),
   .mix_q      (mix_q),
   .mix_phase  (mix_phase),
   .acc_now    (acc_now),
   .tune_now   (tune_now)
);

// File: tb/test_nco_quad_mixer.sv
module test_nco_quad_mixer;

   localparam int CLK_PERIOD = 10;
   localparam int AMP        = 32767;

   logic               clk;
   logic               rst_n;
   logic               samp_valid;
   logic signed [13:0] samp_data;
   logic               tune_load;
   logic [31:0]        tune_word;
   logic               mix_valid;
   logic signed [15:0] mix_i;
   logic signed [15:0] mix_q;
   logic [31:0]        mix_phase;

   nco_quad_mixer i_nco_quad_mixer (
      .clk        (clk),
      .rst_n      (rst_n),
      .samp_valid (samp_valid),
      .samp_data  (samp_data),
      .tune_load  (tune_load),
      .tune_word  (tune_word),
      .mix_valid  (mix_valid),
      .mix_i      (mix_i),
      .mix_q      (mix_q),
      .mix_phase  (mix_phase)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   int nchk = 0;
   int nerr = 0;
   int cyc  = 0;

   // expected-result ring, written four slots ahead
   logic               e_v  [8];
   logic signed [13:0] e_x  [8];
   logic [31:0]        e_ph [8];
   logic               e_ld [8];

   logic [31:0] acc_m  = '0;
   logic [31:0] word_m = '0;
   logic        pend_m = 1'b0;

   function automatic longint rnd_half_up(input longint p);
      return (p + 64'sd4096) >>> 13;
   endfunction

   task automatic check(input string req, input bit ok, input string what,
                        input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   task automatic check_near(input string req, input string what,
                             input longint act, input real exp);
      real d;
      d = real'(act) - exp;
      if (d < 0.0) d = -d;
      nchk++;
      if (d > 1.01) begin
         nerr++;
         $display("FAIL %s %s: actual=%0d expected=%f (cycle %0d)", req, what, act, exp, cyc);
      end
   endtask

   task automatic compare_slot();
      int          s;
      int          k;
      int          quad;
      longint      cv, sv, xi;
      real         ang;
      string       preq;
      s = cyc % 8;
      check("R4", mix_valid == e_v[s], "mix_valid", longint'(mix_valid), longint'(e_v[s]));
      if (e_v[s] && mix_valid) begin
         preq = e_ld[s] ? "R3" : "R2";
         check(preq, mix_phase == e_ph[s], "phase (R5)", longint'(mix_phase), longint'(e_ph[s]));
         check("R9", (mix_i >= -AMP) && (mix_q >= -AMP), "range", longint'(mix_i), -AMP);
         xi = longint'(e_x[s]);
         k  = int'(e_ph[s][31:20]);
         if (xi == 0) begin
            check("R10", mix_i == 0, "I zero", longint'(mix_i), 0);
            check("R10", mix_q == 0, "Q zero", longint'(mix_q), 0);
         end else if (k % 1024 == 0) begin
            quad = k / 1024;
            cv = (quad == 0) ? AMP : (quad == 2) ? -AMP : 0;
            sv = (quad == 1) ? AMP : (quad == 3) ? -AMP : 0;
            check("R8", longint'(mix_i) == rnd_half_up(xi * cv), "I axis",
                  longint'(mix_i), rnd_half_up(xi * cv));
            check("R8", longint'(mix_q) == rnd_half_up(-xi * sv), "Q axis",
                  longint'(mix_q), rnd_half_up(-xi * sv));
         end else begin
            ang = 2.0 * 3.14159265358979 * real'(k) / 4096.0;
            check_near("R6", "I", longint'(mix_i), real'(xi) * real'(AMP) * $cos(ang) / 8192.0);
            check_near("R7", "Q", longint'(mix_q), -real'(xi) * real'(AMP) * $sin(ang) / 8192.0);
         end
      end
   endtask

   task automatic step(input bit v, input logic signed [13:0] x,
                       input bit ld, input logic [31:0] w);
      int s4;
      compare_slot();
      samp_valid = v;
      samp_data  = x;
      tune_load  = ld;
      tune_word  = w;
      s4 = (cyc + 4) % 8;
      e_v[s4]  = v;
      e_x[s4]  = x;
      e_ph[s4] = acc_m;
      e_ld[s4] = pend_m;
      if (v) begin
         acc_m  = acc_m + (ld ? w : word_m);
         pend_m = 1'b0;
      end
      if (ld) begin
         word_m = w;
         pend_m = 1'b1;
      end
      @(posedge clk);
      @(negedge clk);
      cyc++;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      nerr++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      logic [31:0] seed_dummy;
      for (int i = 0; i < 8; i++) begin
         e_v[i] = 1'b0; e_x[i] = '0; e_ph[i] = '0; e_ld[i] = 1'b0;
      end
      rst_n      = 1'b0;
      samp_valid = 1'b0;
      samp_data  = '0;
      tune_load  = 1'b0;
      tune_word  = '0;
      seed_dummy = $urandom(32'h0051_7ACE);
      repeat (5) @(negedge clk);
      // R1: reset state
      check("R1", mix_valid == 1'b0, "valid in reset", longint'(mix_valid), 0);
      check("R1", mix_i == 0, "I in reset", longint'(mix_i), 0);
      check("R1", mix_q == 0, "Q in reset", longint'(mix_q), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", mix_phase == 0, "phase after reset", longint'(mix_phase), 0);

      // quarter-turn steps with full-scale negative input (R8, R9)
      step(1'b1, -14'sd8192, 1'b1, 32'h4000_0000);
      for (int i = 0; i < 7; i++) step(1'b1, -14'sd8192, 1'b0, '0);
      for (int i = 0; i < 4; i++) step(1'b1, 14'sd8191, 1'b0, '0);
      // zero input (R10)
      for (int i = 0; i < 4; i++) step(1'b1, 14'sd0, 1'b0, '0);
      // load without sample, then gapped samples (R3, R2)
      step(1'b0, 14'sd0, 1'b1, 32'h0012_3457);
      step(1'b0, 14'sd0, 1'b0, '0);
      for (int i = 0; i < 3; i++) step(1'b1, 14'sd1000, 1'b0, '0);
      step(1'b0, 14'sd5, 1'b0, '0);
      step(1'b1, -14'sd3000, 1'b1, 32'hFFF0_0000);
      for (int i = 0; i < 6; i++) step(1'b1, 14'sd4321, 1'b0, '0);
      // constrained random traffic
      for (int i = 0; i < 3000; i++) begin
         bit          rv;
         bit          rl;
         logic [31:0] rw;
         rv = ($urandom % 4) != 0;
         rl = ($urandom % 64) == 0;
         rw = $urandom;
         step(rv, 14'($urandom), rl, rw);
      end
      for (int i = 0; i < 6; i++) step(1'b0, 14'sd0, 1'b0, '0);

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule